// File: doc/BRIEF.md
# Cascaded Multi-Tap Line Delay

This block produces several copies of one input stream, each delayed by a whole number of lines. The stages sit in a chain. The first stage is a line memory with its own write port. Each later stage is fed internally from the stage in front of it, so no external wiring is needed between stages. Tap 0 gives the stream one line late, tap 1 two lines late, and so on up to `STAGES` lines. `DEPTH` sets the line length in words.

The first stage has its own write clock, write enable and write reset. Everything after the first stage's write side runs on the read clock: the read of every stage and the write into every downstream stage. One active-low read enable and one active-low read reset control all of that logic together.

Each tap has a data field and a drive-enable bit. The drive-enable bit is meant to control a tri-state pad buffer. It is low whenever the tap was not read on the last read edge, so the pad would float.

Top module: `cld_cascade_delay`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_rst_n` high and `wr_en_n` low, stage 0 stores `wr_data` at its write address and the write address advances. With `wr_en_n` high, nothing is stored and the write address holds.
- R2: A rising `wr_clk` edge with `wr_rst_n` low returns the write address to 0 and stores nothing, whatever `wr_en_n` is.
- R3: On a rising `rd_clk` edge with `rd_rst_n` high and `rd_en_n` low, every tap loads its stage's word at the shared read address. After that edge every bit of `tap_oe` is 1.
- R4: On a rising `rd_clk` edge with `rd_rst_n` high and `rd_en_n` high, several things hold:
  - every bit of `tap_oe` is 0 after the edge;
  - every tap keeps its data;
  - the shared read address does not move;
  - no downstream stage is written.
- R5: A rising `rd_clk` edge with `rd_rst_n` low has these effects, whatever `rd_en_n` is:
  - the shared address returns to 0; this address is stage 0's read address and the read and write address of every downstream stage;
  - every bit of `tap_oe` becomes 0;
  - no downstream stage is written.
- R6: Every address counts 0 to `DEPTH`-1 and then wraps to 0.
- R7: Both ports can run in lockstep: one clock, both resets released in the same cycle, both enables equal. In that case the tap with index k (bits `k*WIDTH +: WIDTH` of `tap_data`, k starting at 0) holds, after enabled cycle n, the word written on enabled cycle n-(k+1)*`DEPTH`.
- R8: A downstream stage reads and writes the same address on the same read edge. The tap gets the word from the previous line at that address. The stage then stores the word that the upstream stage gives out on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock of stage 0 |
| wr_en_n | input | 1 | Write enable of stage 0, active low |
| wr_rst_n | input | 1 | Synchronous write-address reset of stage 0, active low |
| wr_data | input | WIDTH | Input stream word |
| rd_clk | input | 1 | Clock for every read and for every downstream write |
| rd_en_n | input | 1 | Shared read enable, active low |
| rd_rst_n | input | 1 | Shared synchronous read-side address reset, active low |
| tap_data | output | STAGES*WIDTH | Tap words; tap k occupies bits k*WIDTH +: WIDTH |
| tap_oe | output | STAGES | Per-tap pad drive enable; 0 means high impedance |

## Verification
The assertions make two assumptions about the inputs:
- Each address counter is cleared once by its own reset before its checks start, so no assertion is armed before that first reset.
- The control inputs are stable around the clock edge.

The stimulus meets both. It drives every input on the falling edge of the one shared clock, and it resets both pointers before any other traffic. The data-path checks apply the line-delay relation only once (k+1) full lines have been written since the last reset. They also keep both enables equal, so words left over from an earlier run and cycles where one pointer moves without the other are never scored.

// File: rtl/cld_pkg.sv
`timescale 1ns/1ps
package cld_pkg;

   // action taken by a line address counter on its clock edge
   typedef enum logic [1:0] {
      PTR_HOLD  = 2'd0,
      PTR_STEP  = 2'd1,
      PTR_CLEAR = 2'd2
   } ptr_op_e;

   // counter width for a line of the given length (length of at least 2)
   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/cld_line_ptr.sv
`timescale 1ns/1ps
module cld_line_ptr
   import cld_pkg::*;
#(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned AW    = addr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          clr_n,
   input  logic          step_n,
   output logic [AW-1:0] ptr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   ptr_op_e op;
   logic    armed = 1'b0;

   always_comb begin
      if (!clr_n)       op = PTR_CLEAR;
      else if (!step_n) op = PTR_STEP;
      else              op = PTR_HOLD;
   end

   always_ff @(posedge clk) begin
      unique case (op)
         PTR_CLEAR: ptr <= '0;
         PTR_STEP:  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
         default:   ptr <= ptr;
      endcase
   end

   // checks are armed by the first clear
   always_ff @(posedge clk) begin
      if (!clr_n) armed <= 1'b1;
   end

   p_ptr_range_r6: assert property (@(posedge clk) disable iff (!armed)
      ptr <= LAST);

   p_ptr_clear_r5: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> ptr == '0);

   p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && step_n) |=> $stable(ptr));

   p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !step_n && ptr == LAST) |=> ptr == '0);

   p_ptr_step_r1: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !step_n && ptr != LAST) |=> ptr == AW'($past(ptr) + 1'b1));

endmodule

// File: rtl/cld_line_ram.sv
`timescale 1ns/1ps
module cld_line_ram #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 512,
   parameter int unsigned AW    = 9
) (
   input  logic             wclk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   // unregistered read: the capturing tap register sees the pre-write word
   assign rdata = mem[raddr];

endmodule

// File: rtl/cld_tap_reg.sv
`timescale 1ns/1ps
module cld_tap_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             oe
);

   logic armed = 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe <= 1'b0;
      end else if (!rd_n) begin
         q  <= d;
         oe <= 1'b1;
      end else begin
         oe <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b1;
   end

   p_tap_idle_r4: assert property (@(posedge clk) disable iff (!armed)
      (rst_n && rd_n) |=> (!oe && $stable(q)));

   p_tap_live_r3: assert property (@(posedge clk) disable iff (!armed)
      (rst_n && !rd_n) |=> oe);

   p_tap_rst_r5: assert property (@(posedge clk) disable iff (!armed)
      !rst_n |=> !oe);

endmodule

// File: rtl/cld_cascade_delay.sv
`timescale 1ns/1ps
module cld_cascade_delay
   import cld_pkg::*;
#(
   parameter int unsigned STAGES = 3,
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned WIDTH  = 8
) (
   input  logic                    wr_clk,
   input  logic                    wr_en_n,
   input  logic                    wr_rst_n,
   input  logic [WIDTH-1:0]        wr_data,
   input  logic                    rd_clk,
   input  logic                    rd_en_n,
   input  logic                    rd_rst_n,
   output logic [STAGES*WIDTH-1:0] tap_data,
   output logic [STAGES-1:0]       tap_oe
);

   localparam int unsigned AW = addr_bits(DEPTH);

   if (STAGES < 1) begin : g_bad_stages
      $error("cld_cascade_delay: STAGES must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("cld_cascade_delay: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cld_cascade_delay: WIDTH must be at least 1");
   end

   logic [AW-1:0]    wptr;
   logic [AW-1:0]    rptr;
   logic [WIDTH-1:0] stage_word [STAGES];
   logic             cascade_we;

   // stage 0 write address, on the write clock
   cld_line_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
      .clk    (wr_clk),
      .clr_n  (wr_rst_n),
      .step_n (wr_en_n),
      .ptr    (wptr)
   );

   // one address serves stage 0 reads and every downstream read and write
   cld_line_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
      .clk    (rd_clk),
      .clr_n  (rd_rst_n),
      .step_n (rd_en_n),
      .ptr    (rptr)
   );

   assign cascade_we = rd_rst_n && !rd_en_n;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_head
         cld_line_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
            .wclk  (wr_clk),
            .we    (wr_rst_n && !wr_en_n),
            .waddr (wptr),
            .wdata (wr_data),
            .raddr (rptr),
            .rdata (stage_word[k])
         );
      end else begin : g_link
         cld_line_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
            .wclk  (rd_clk),
            .we    (cascade_we),
            .waddr (rptr),
            .wdata (stage_word[k-1]),
            .raddr (rptr),
            .rdata (stage_word[k])
         );
      end

      cld_tap_reg #(.WIDTH(WIDTH)) u_tap (
         .clk   (rd_clk),
         .rst_n (rd_rst_n),
         .rd_n  (rd_en_n),
         .d     (stage_word[k]),
         .q     (tap_data[k*WIDTH +: WIDTH]),
         .oe    (tap_oe[k])
      );
   end

   logic rd_armed = 1'b0;
   always_ff @(posedge rd_clk) begin
      if (!rd_rst_n) rd_armed <= 1'b1;
   end

   // tap registers are separate flops but must always switch together
   p_taps_agree_r3: assert property (@(posedge rd_clk) disable iff (!rd_armed)
      ($countones(tap_oe) == 0) || ($countones(tap_oe) == STAGES));

   p_taps_float_r4: assert property (@(posedge rd_clk) disable iff (!rd_armed)
      (rd_rst_n && rd_en_n) |=> $stable(tap_data));

endmodule

// File: tb/sim_cld_cascade_delay.sv
`timescale 1ns/1ps
module sim_cld_cascade_delay;

   localparam int W = 8;
   localparam int D = 5;
   localparam int S = 3;

   logic           clk = 1'b0;
   logic           wr_en_n = 1'b1, wr_rst_n = 1'b1;
   logic           rd_en_n = 1'b1, rd_rst_n = 1'b1;
   logic [W-1:0]   wr_data = '0;
   logic [S*W-1:0] tap_data;
   logic [S-1:0]   tap_oe;

   always #10 clk = ~clk;

   cld_cascade_delay #(.STAGES(S), .DEPTH(D), .WIDTH(W)) u0 (
      .wr_clk   (clk),
      .wr_en_n  (wr_en_n),
      .wr_rst_n (wr_rst_n),
      .wr_data  (wr_data),
      .rd_clk   (clk),
      .rd_en_n  (rd_en_n),
      .rd_rst_n (rd_rst_n),
      .tap_data (tap_data),
      .tap_oe   (tap_oe)
   );

   int       checks = 0;
   int       fails  = 0;
   bit       done   = 1'b0;
   int       n      = 0;
   int       seed   = 0;
   int       stepv  = 1;
   logic [W-1:0] last [S];

   function automatic logic [W-1:0] pattern(input int j);
      return W'(seed + stepv * j);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // inputs change on the falling edge; outputs are sampled on the next one
   task automatic cyc(input logic wen, input logic ren, input logic wrs,
                      input logic rrs, input logic [W-1:0] d);
      wr_en_n  = wen;
      rd_en_n  = ren;
      wr_rst_n = wrs;
      rd_rst_n = rrs;
      wr_data  = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run(input int cnt, input string tag0);
      for (int c = 0; c < cnt; c++) begin
         cyc(1'b0, 1'b0, 1'b1, 1'b1, pattern(n));
         chk(tap_oe == '1, "R3", int'(tap_oe), (1 << S) - 1);
         for (int k = 0; k < S; k++) begin
            last[k] = tap_data[k*W +: W];
            if (n >= (k + 1) * D) begin
               chk(tap_data[k*W +: W] == pattern(n - (k + 1) * D),
                   (k == 0) ? tag0 : ((k == 1) ? "R8" : "R7"),
                   int'(tap_data[k*W +: W]), int'(pattern(n - (k + 1) * D)));
            end
         end
         n++;
      end
   endtask

   task automatic pause(input int cnt);
      for (int c = 0; c < cnt; c++) begin
         cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'hEE);
         chk(tap_oe == '0, "R4", int'(tap_oe), 0);
         for (int k = 0; k < S; k++) begin
            chk(tap_data[k*W +: W] == last[k], "R4",
                int'(tap_data[k*W +: W]), int'(last[k]));
         end
      end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      @(negedge clk);

      // reset state: both pointers cleared, taps not driving (R5)
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      chk(tap_oe == '0, "R5", int'(tap_oe), 0);

      // counting pattern through several line wraps (R6, R7, R8)
      n = 0; seed = 0; stepv = 1;
      run(22, "R6");
      // both sides idle with junk data: nothing stored, nothing moves (R1, R4)
      pause(3);
      run(12, "R1");

      // separate resets at a nonzero address (R2, R5)
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'hEE);
      chk(tap_oe == '0, "R4", int'(tap_oe), 0);
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'hEE);
      chk(tap_oe == '0, "R5", int'(tap_oe), 0);
      n = 0; seed = 8'h40; stepv = 7;
      run(20, "R2");

      // resets together with both enables low: reset wins (R2, R5)
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'hEE);
      chk(tap_oe == '0, "R5", int'(tap_oe), 0);
      n = 0; seed = 200; stepv = 3;
      run(8, "R7");
      pause(2);
      run(17, "R7");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule